// File: doc/BRIEF.md
# 64-bit Load/Store Access Unit

This unit executes the three memory instructions that exist only in the 64-bit integer instruction set: load word unsigned, load doubleword and store doubleword. It takes a 32-bit instruction word together with the values of its two source registers. It forms the effective address as the base register plus a sign-extended 12-bit offset. It then issues one request on a simple ready/valid memory port, and for loads it produces a 64-bit register writeback value.

The unit handles one instruction at a time. The unit takes an instruction in a cycle where `in_valid` and `in_accept` are both high. The memory request appears in the next cycle and stays unchanged until the memory raises `mem_req_ready`. A store then completes. A load waits for `mem_rsp_valid` and delivers its writeback in that same cycle. An encoding outside the three supported forms is flagged at once and produces no memory traffic.

Top module: `mem64_access_unit`

## Requirements
- R1: The unit decodes from opcode bits [6:0] and funct3 bits [14:12]. Opcode 0000011 with funct3 110 is load word unsigned, and opcode 0000011 with funct3 011 is load doubleword. Opcode 0100011 with funct3 011 is store doubleword. `mem_req_write` is 1 only for the store. The destination register is taken from bits [11:7].
- R2: The request address is `in_rs1` plus the sign-extended 12-bit offset, modulo 2^64. Loads take the offset from bits [31:20]. The store takes offset bits [11:5] from instruction bits [31:25] and offset bits [4:0] from instruction bits [11:7].
- R3: `mem_req_size` is 2'b10 for the word load and 2'b11 for the doubleword forms. `mem_req_strb` is 8'hFF for doubleword. For the word load it is 8'h0F when address bit 2 is 0 and 8'hF0 when address bit 2 is 1.
- R4: `in_accept` is high only when the unit is idle. An instruction that is accepted and legal raises `mem_req_valid` in the next cycle. The address, size, strobes, write flag and data stay stable until the cycle in which `mem_req_ready` is high. While the unit is busy, `in_valid` has no effect.
- R5: The word load returns the 32-bit half of `mem_rsp_rdata` chosen by address bit 2 (bit 2 = 1 selects bits [63:32]), zero-extended to 64 bits.
- R6: The doubleword load returns all 64 bits of `mem_rsp_rdata` unchanged.
- R7: The store drives `mem_req_wdata` with the full `in_rs2` value captured at acceptance. It makes no writeback, and the unit is idle again in the cycle after `mem_req_ready`.
- R8: A load with destination register 0 still issues its request and waits for its response, but `wb_en` stays 0.
- R9: `bad_instr` is high in the cycle in which an unsupported encoding is presented while the unit is idle. No request follows, and the unit stays idle.
- R10: `wb_en` is high only in the cycle in which `mem_rsp_valid` answers an outstanding load. In that cycle `wb_rd` equals the destination field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented |
| in_instr | input | 32 | Instruction word |
| in_rs1 | input | 64 | Base register value |
| in_rs2 | input | 64 | Store data register value |
| in_accept | output | 1 | Unit idle, takes the presented instruction |
| bad_instr | output | 1 | Unsupported encoding presented while idle |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 64 | Effective byte address |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_size | output | 2 | 2'b10 word, 2'b11 doubleword |
| mem_req_strb | output | 8 | Byte lanes touched |
| mem_req_wdata | output | 64 | Store data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 64 | Read data, aligned 64-bit lane |
| wb_en | output | 1 | Register writeback this cycle |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Writeback value |

## Verification
The assertions assume that the memory raises `mem_rsp_valid` only while a load is waiting for its data, and that accesses are naturally aligned. The assertions also assume that instruction fields do not change within a cycle. The stimulus respects these assumptions. Its responder returns data only when its own model has a load outstanding, and every base and offset pair is chosen to give an aligned address, including the pair that wraps past the top of the address space. While the unit is busy, the bench also keeps `in_valid` toggling with a legal store, so that it can check the input is ignored.

// File: rtl/mem64_pkg.sv
package mem64_pkg;

  typedef enum logic [1:0] {
    MOP_BAD  = 2'd0,
    MOP_LDWU = 2'd1,
    MOP_LDD  = 2'd2,
    MOP_STD  = 2'd3
  } mop_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_AWAIT = 2'd2
  } phase_e;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [2:0] F3_WORDU  = 3'b110;
  localparam logic [2:0] F3_DWORD  = 3'b011;
  localparam logic [1:0] SIZE_W    = 2'b10;
  localparam logic [1:0] SIZE_D    = 2'b11;

  function automatic mop_e classify(input logic [31:0] ins);
    mop_e k;
    k = MOP_BAD;
    if (ins[6:0] == OPC_LOAD && ins[14:12] == F3_WORDU)       k = MOP_LDWU;
    else if (ins[6:0] == OPC_LOAD && ins[14:12] == F3_DWORD)  k = MOP_LDD;
    else if (ins[6:0] == OPC_STORE && ins[14:12] == F3_DWORD) k = MOP_STD;
    return k;
  endfunction

  function automatic logic [11:0] load_offset(input logic [31:0] ins);
    return ins[31:20];
  endfunction

  function automatic logic [11:0] store_offset(input logic [31:0] ins);
    return {ins[31:25], ins[11:7]};
  endfunction

endpackage

// File: rtl/mem64_decode.sv
module mem64_decode
  import mem64_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] base,
  output mop_e            op,
  output logic [4:0]      rd,
  output logic [XLEN-1:0] ea
);

  logic [11:0] ofs;

  function automatic logic [XLEN-1:0] sext12(input logic [11:0] v);
    return {{(XLEN-12){v[11]}}, v};
  endfunction

  always_comb begin
    op  = classify(instr);
    ofs = (op == MOP_STD) ? store_offset(instr) : load_offset(instr);
    ea  = base + sext12(ofs);
    rd  = instr[11:7];
  end

endmodule

// File: rtl/mem64_strobe.sv
module mem64_strobe
  import mem64_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int NB  = XLEN / 8,
  localparam int NW  = XLEN / 32,
  localparam int WSW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [WSW-1:0] word_sel,
  input  logic [1:0]     size,
  output logic [NB-1:0]  strb
);

  for (genvar g = 0; g < NW; g++) begin : g_word
    assign strb[g*4 +: 4] = (size == SIZE_D || word_sel == WSW'(g)) ? 4'hF : 4'h0;
  end

endmodule

// File: rtl/mem64_extend.sv
module mem64_extend
  import mem64_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int NW  = XLEN / 32,
  localparam int WSW = (NW > 1) ? $clog2(NW) : 1
) (
  input  mop_e            op,
  input  logic [WSW-1:0]  word_sel,
  input  logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] value
);

  function automatic logic [XLEN-1:0] zext_word(input logic [31:0] w);
    return XLEN'(w);
  endfunction

  logic [31:0] word;

  always_comb begin
    word  = rdata[word_sel*32 +: 32];
    value = (op == MOP_LDWU) ? zext_word(word) : rdata;
  end

endmodule

// File: rtl/mem64_access_unit.sv
module mem64_access_unit
  import mem64_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int NB  = XLEN / 8,
  localparam int NW  = XLEN / 32,
  localparam int WSW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  output logic            in_accept,
  output logic            bad_instr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  output logic            mem_req_write,
  output logic [1:0]      mem_req_size,
  output logic [NB-1:0]   mem_req_strb,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  output logic            wb_en,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data
);

  phase_e          state;
  mop_e            r_op;
  logic [4:0]      r_rd;
  logic [XLEN-1:0] r_addr;
  logic [XLEN-1:0] r_wdata;

  mop_e            dec_op;
  logic [4:0]      dec_rd;
  logic [XLEN-1:0] dec_ea;

  // Named events, visible to the assertions below
  logic accept_fire;
  logic start_fire;
  logic req_fire;
  logic rsp_fire;
  logic [WSW-1:0] word_sel;

  mem64_decode #(.XLEN(XLEN)) u_decode (
    .instr (in_instr),
    .base  (in_rs1),
    .op    (dec_op),
    .rd    (dec_rd),
    .ea    (dec_ea)
  );

  assign accept_fire = in_valid && (state == PH_IDLE);
  assign start_fire  = accept_fire && (dec_op != MOP_BAD);
  assign req_fire    = (state == PH_ISSUE) && mem_req_ready;
  assign rsp_fire    = (state == PH_AWAIT) && mem_rsp_valid;
  assign word_sel    = r_addr[2 +: WSW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      r_op    <= MOP_BAD;
      r_rd    <= '0;
      r_addr  <= '0;
      r_wdata <= '0;
    end else begin
      case (state)
        PH_IDLE: if (start_fire) begin
          state   <= PH_ISSUE;
          r_op    <= dec_op;
          r_rd    <= dec_rd;
          r_addr  <= dec_ea;
          r_wdata <= in_rs2;
        end
        PH_ISSUE: if (req_fire) state <= (r_op == MOP_STD) ? PH_IDLE : PH_AWAIT;
        PH_AWAIT: if (rsp_fire) state <= PH_IDLE;
        default:  state <= PH_IDLE;
      endcase
    end
  end

  assign in_accept     = (state == PH_IDLE);
  assign bad_instr     = accept_fire && (dec_op == MOP_BAD);
  assign mem_req_valid = (state == PH_ISSUE);
  assign mem_req_addr  = r_addr;
  assign mem_req_write = (r_op == MOP_STD);
  assign mem_req_size  = (r_op == MOP_LDWU) ? SIZE_W : SIZE_D;
  assign mem_req_wdata = r_wdata;

  mem64_strobe #(.XLEN(XLEN)) u_strobe (
    .word_sel (word_sel),
    .size     (mem_req_size),
    .strb     (mem_req_strb)
  );

  mem64_extend #(.XLEN(XLEN)) u_extend (
    .op       (r_op),
    .word_sel (word_sel),
    .rdata    (mem_rsp_rdata),
    .value    (wb_data)
  );

  assign wb_en = rsp_fire && (r_rd != 5'd0);
  assign wb_rd = r_rd;

  // R4: a stalled request holds every field
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_size) && $stable(mem_req_wdata) && $stable(mem_req_write) &&
      $stable(mem_req_strb));

  // R4: a legal accepted instruction becomes a request next cycle, unit busy
  assert_start_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire && !bad_instr |=> mem_req_valid && !in_accept);

  // R9: an unsupported encoding never produces a request
  assert_bad_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_instr |=> !mem_req_valid && in_accept);

  // R7: store frees the unit right after the memory takes it
  assert_store_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && mem_req_write |=> in_accept);

  // R3: strobe width matches the size code
  assert_strb_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $countones(mem_req_strb) == ((mem_req_size == SIZE_W) ? 4 : NB));

  // R10: writeback only while a load is outstanding and data arrives
  assert_wb_on_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_rsp_valid && !mem_req_valid && !in_accept && !mem_req_write);

endmodule

// File: tb/test_mem64_access_unit.sv
module test_mem64_access_unit;

  localparam int N = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [63:0] in_rs1 = '0, in_rs2 = '0;
  logic        in_accept, bad_instr, mem_req_valid, mem_req_write, wb_en;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [63:0] mem_req_addr, mem_req_wdata, wb_data;
  logic [63:0] mem_rsp_rdata = '0;
  logic [1:0]  mem_req_size;
  logic [7:0]  mem_req_strb;
  logic [4:0]  wb_rd;

  always #2.5 clk = ~clk;

  mem64_access_unit i_mem64_access_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_accept(in_accept), .bad_instr(bad_instr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
    .mem_req_size(mem_req_size), .mem_req_strb(mem_req_strb),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  int vectors = 0, fails = 0, cyc = 0, idx = 0, dly = 1;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Kinds: 0 unsupported, 1 word unsigned load, 2 doubleword load, 3 doubleword store
  function automatic int bkind(input logic [31:0] i);
    case ({i[14:12], i[6:0]})
      {3'd6, 7'h03}: return 1;
      {3'd3, 7'h03}: return 2;
      {3'd3, 7'h23}: return 3;
      default:       return 0;
    endcase
  endfunction

  function automatic logic [63:0] boff(input logic [31:0] i);
    logic [11:0] o;
    o = (i[6:0] == 7'h23) ? {i[31:25], i[11:7]} : i[31:20];
    return 64'($signed(o));
  endfunction

  function automatic logic [31:0] enc_ld(input logic [2:0] f3, input logic [4:0] rd,
                                         input logic [11:0] imm);
    return {imm, 5'd11, f3, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] enc_st(input logic [2:0] f3, input logic [11:0] imm);
    return {imm[11:5], 5'd12, 5'd13, f3, imm[4:0], 7'b0100011};
  endfunction

  logic [63:0] bmem [logic [63:0]];

  function automatic logic [63:0] bread(input logic [63:0] a);
    logic [63:0] k;
    k = a >> 3;
    if (bmem.exists(k)) return bmem[k];
    return (k + 64'd3) * 64'h9E37_79B9_7F4A_7C15;
  endfunction

  logic [31:0] q_ins [N];
  logic [63:0] q_rs1 [N];
  logic [63:0] q_rs2 [N];

  // Reference model state: 0 idle, 1 request pending, 2 awaiting data
  int          m_phase = 0, m_kind = 0;
  logic [4:0]  m_rd = '0;
  logic [63:0] m_addr = '0, m_wdata = '0;

  always @(posedge clk) begin
    if (!rst_n) m_phase = 0;
    else case (m_phase)
      0: if (in_valid && bkind(in_instr) != 0) begin
        m_kind  = bkind(in_instr);
        m_rd    = in_instr[11:7];
        m_addr  = in_rs1 + boff(in_instr);
        m_wdata = in_rs2;
        m_phase = 1;
      end
      1: if (mem_req_ready) begin
        if (m_kind == 3) begin
          bmem[m_addr >> 3] = m_wdata;
          m_phase = 0;
        end else m_phase = 2;
      end
      default: if (mem_rsp_valid) m_phase = 0;
    endcase
  end

  // Stimulus and memory responder
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      in_valid      = 1'b0;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_rdata = {32'(cyc) ^ 32'hA5A5_0F0F, ~32'(cyc)};
      if (rst_n) begin
        if (m_phase == 0) begin
          if (idx < N && (cyc % 4) != 3) begin
            in_valid = 1'b1;
            in_instr = q_ins[idx];
            in_rs1   = q_rs1[idx];
            in_rs2   = q_rs2[idx];
            idx++;
          end
        end else begin
          // R4: legal store offered while busy must be ignored
          in_valid = cyc[0];
          in_instr = enc_st(3'd3, 12'h010);
          in_rs1   = 64'h5000;
          in_rs2   = 64'h1111_2222_3333_4444;
          if (m_phase == 1) mem_req_ready = (cyc % 3) != 1;
          else if (dly == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = bread(m_addr);
            dly = cyc % 3;
          end else dly--;
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic        exp_wb;
      logic [63:0] exp_val, rd_data;
      chk("R4", "in_accept", 64'(in_accept), 64'(m_phase == 0));
      chk("R9", "bad_instr", 64'(bad_instr),
          64'(m_phase == 0 && in_valid && bkind(in_instr) == 0));
      chk("R4", "mem_req_valid", 64'(mem_req_valid), 64'(m_phase == 1));
      if (m_phase == 1) begin
        chk("R2", "mem_req_addr", mem_req_addr, m_addr);
        chk("R3", "mem_req_size", 64'(mem_req_size), (m_kind == 1) ? 64'd2 : 64'd3);
        chk("R3", "mem_req_strb", 64'(mem_req_strb),
            (m_kind != 1) ? 64'hFF : (m_addr[2] ? 64'hF0 : 64'h0F));
        chk("R1", "mem_req_write", 64'(mem_req_write), 64'(m_kind == 3));
        if (m_kind == 3) chk("R7", "mem_req_wdata", mem_req_wdata, m_wdata);
      end
      exp_wb = (m_phase == 2) && mem_rsp_valid && (m_rd != 5'd0);
      chk((m_rd == 5'd0) ? "R8" : "R10", "wb_en", 64'(wb_en), 64'(exp_wb));
      if (exp_wb) begin
        rd_data = mem_rsp_rdata;
        exp_val = (m_kind == 1) ? {32'd0, (m_addr[2] ? rd_data[63:32] : rd_data[31:0])}
                                : rd_data;
        chk("R10", "wb_rd", 64'(wb_rd), 64'(m_rd));
        chk((m_kind == 1) ? "R5" : "R6", "wb_data", wb_data, exp_val);
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", idx, N);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // Supported and unsupported encodings; all addresses aligned
    q_ins[0]  = enc_ld(3'd3, 5'd5, 12'h010);  q_rs1[0]  = 64'h1000;  q_rs2[0]  = '0;
    q_ins[1]  = enc_ld(3'd6, 5'd6, 12'h000);  q_rs1[1]  = 64'h2000;  q_rs2[1]  = '0;
    q_ins[2]  = enc_ld(3'd6, 5'd7, 12'h004);  q_rs1[2]  = 64'h2000;  q_rs2[2]  = '0;
    q_ins[3]  = enc_st(3'd3, 12'h7E8);        q_rs1[3]  = 64'h3000;
    q_rs2[3]  = 64'h8123_4567_89AB_CDEF;
    q_ins[4]  = enc_ld(3'd3, 5'd8, 12'h7E8);  q_rs1[4]  = 64'h3000;  q_rs2[4]  = '0;
    q_ins[5]  = enc_ld(3'd6, 5'd9, 12'h7EC);  q_rs1[5]  = 64'h3000;  q_rs2[5]  = '0;
    q_ins[6]  = enc_st(3'd3, 12'hFF8);        q_rs1[6]  = 64'h1000;
    q_rs2[6]  = 64'hDEAD_BEEF_0BAD_F00D;
    q_ins[7]  = enc_ld(3'd3, 5'd10, 12'hFF0); q_rs1[7]  = 64'h1008;  q_rs2[7]  = '0;
    q_ins[8]  = enc_ld(3'd3, 5'd0, 12'h000);  q_rs1[8]  = 64'h40;    q_rs2[8]  = '0;
    q_ins[9]  = enc_ld(3'd2, 5'd4, 12'h000);  q_rs1[9]  = 64'h80;    q_rs2[9]  = '0;
    q_ins[10] = {12'h008, 5'd1, 3'd3, 5'd4, 7'b0010011};
    q_rs1[10] = 64'h80; q_rs2[10] = '0;
    q_ins[11] = enc_st(3'd2, 12'h000);        q_rs1[11] = 64'h80;    q_rs2[11] = 64'h5;
    q_ins[12] = enc_ld(3'd3, 5'd31, 12'h010); q_rs1[12] = 64'hFFFF_FFFF_FFFF_FFF8;
    q_rs2[12] = '0;
    q_ins[13] = enc_ld(3'd6, 5'd1, 12'hFFC);  q_rs1[13] = 64'h8;     q_rs2[13] = '0;
    q_ins[14] = enc_st(3'd3, 12'h800);        q_rs1[14] = 64'h10000;
    q_rs2[14] = 64'h0123_4567_89AB_CDEF;

    repeat (3) @(negedge clk);
    // Reset state: idle, no request, no writeback
    chk("R4", "reset in_accept", 64'(in_accept), 64'd1);
    chk("R4", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R10", "reset wb_en", 64'(wb_en), 64'd0);
    chk("R9", "reset bad_instr", 64'(bad_instr), 64'd0);
    rst_n = 1'b1;

    wait (idx == N && m_phase == 0);
    repeat (4) @(posedge clk);
    #2;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule